// File: doc/BRIEF.md
# Memory-Mapped Store Routing Unit

This unit sits between the load/store execute stage of a processor and its data cache. Each request carries a base, an immediate and store data. The unit forms the effective address as base plus immediate. It then sends the access either to the data-cache port or to a small bank of five 32-bit memory-mapped registers, choosing by address window. The register bank is separate from the processor's general register file. All five register values are driven out in parallel so that attached network logic can read them.

There are three request types besides idle: ordinary load, ordinary store and register-store. A register-store always targets the bank. Alongside the request port there is a one-bit send strobe that needs no operands. It writes the constant 1 into the doorbell register, which is the fifth register at 0x4010, and it can arrive in the same cycle as any request.

Top module: `mmio_route_unit`

## Requirements
- R1: A synchronous active-high reset clears all five registers to zero and holds `rd_valid_o` low in the following cycle.
- R2: For every request type, `cache_addr_o` shows `req_base_i + req_imm_i` (modulo 2^16) in the same cycle, and `cache_wdata_o` shows `req_wdata_i`.
- R3: A register-store (`req_op_i` = 2'b11) writes `req_wdata_i` into the register selected by effective-address bits [4:2], whatever the window. It never asserts `cache_we_o` or `cache_re_o`.
- R4: An ordinary store (`req_op_i` = 2'b10) whose effective address is 0x4000 or above writes the selected register and keeps `cache_we_o` low.
- R5: An ordinary store whose effective address is below 0x4000 asserts `cache_we_o` in that cycle and leaves all five registers unchanged.
- R6: A high `send_i` writes 1 into register 4 (address 0x4010), visible on `regs_o` after the clock edge.
- R7: When a register write to register 4 and `send_i` occur in the same cycle, register 4 becomes 1. A concurrent write to any other register still takes effect.
- R8: Effective-address bits [1:0] are ignored. Register k is selected for any address from 0x4000+4k through 0x4003+4k.
- R9: A load (`req_op_i` = 2'b01) at 0x4000 or above keeps `cache_re_o` low. In the next cycle `rd_valid_o` is high and `rd_data_o` holds the selected register's value from before that cycle's clock edge.
- R10: A load below 0x4000 asserts `cache_re_o` in the same cycle. In the next cycle `rd_valid_o` is high and `rd_data_o` follows `cache_rdata_i` directly.
- R11: `regs_o` carries register k in bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_op_i | input | 2 | Request type: 00 idle, 01 load, 10 store, 11 register-store |
| req_base_i | input | 16 | Base address |
| req_imm_i | input | 16 | Immediate added to the base |
| req_wdata_i | input | 32 | Store data |
| send_i | input | 1 | Send strobe: writes 1 to the doorbell register |
| cache_addr_o | output | 16 | Effective address to the cache |
| cache_wdata_o | output | 32 | Write data to the cache |
| cache_we_o | output | 1 | Cache write enable |
| cache_re_o | output | 1 | Cache read enable |
| cache_rdata_i | input | 32 | Read data from the cache |
| rd_valid_o | output | 1 | Load result valid (one cycle after the load) |
| rd_data_o | output | 32 | Load result |
| regs_o | output | 160 | All five register values, register k at bits [32k+31:32k] |

## Verification
The hardest situations to reach are the collisions inside a single cycle. One is a send strobe together with a register-store aimed at the doorbell. Another is a send together with a store to a different register. A third is a send together with a load of the doorbell, which must still return the old value. The stimulus first writes a non-1 value into the doorbell so that the override is visible. It then issues each collision as one combined request. A scoreboard records the pre-edge register value for every load and compares it when `rd_valid_o` rises.

// File: rtl/mmio_route_pkg.sv
package mmio_route_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_REGST = 2'b11
    } req_op_e;

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
    import mmio_route_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter logic [ADDR_W-1:0] PERIPH_BASE = 16'h4000
) (
    input  req_op_e           op_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] imm_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              cache_we_o,
    output logic              cache_re_o,
    output logic              bank_we_o,
    output logic              bank_re_o
);

    logic in_window;

    always_comb begin
        ea_o       = base_i + imm_i;
        in_window  = (ea_o >= PERIPH_BASE);
        // word select; the two byte-offset bits never reach the bank
        idx_o      = ea_o[IDX_W+1:2];
        cache_we_o = 1'b0;
        cache_re_o = 1'b0;
        bank_we_o  = 1'b0;
        bank_re_o  = 1'b0;
        unique case (op_i)
            OP_LOAD: begin
                cache_re_o = !in_window;
                bank_re_o  = in_window;
            end
            OP_STORE: begin
                cache_we_o = !in_window;
                bank_we_o  = in_window;
            end
            OP_REGST: begin
                bank_we_o  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mmio_reg_bank.sv
module mmio_reg_bank #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 5,
    parameter int IDX_W    = 3
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       we_i,
    input  logic [IDX_W-1:0]           widx_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic                       send_i,
    input  logic                       rd_req_i,
    input  logic                       bank_re_i,
    input  logic [IDX_W-1:0]           ridx_i,
    output logic [NUM_REGS*DATA_W-1:0] regs_o,
    output logic                       rd_valid_o,
    output logic                       rd_bank_o,
    output logic [DATA_W-1:0]          rd_data_o
);

    localparam int DOORBELL = NUM_REGS - 1;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            rvalid;
        logic                            rbank;
        logic [DATA_W-1:0]               rdata;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.rvalid = rd_req_i;
        state_d.rbank  = bank_re_i;
        state_d.rdata  = '0;
        if (bank_re_i && (int'(ridx_i) < NUM_REGS)) begin
            state_d.rdata = state_q.regs[ridx_i];
        end
        if (we_i && (int'(widx_i) < NUM_REGS)) begin
            state_d.regs[widx_i] = wdata_i;
        end
        // doorbell strobe overrides a same-cycle data write
        if (send_i) begin
            state_d.regs[DOORBELL] = DATA_W'(1);
        end
        if (rst_i) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign regs_o     = state_q.regs;
    assign rd_valid_o = state_q.rvalid;
    assign rd_bank_o  = state_q.rbank;
    assign rd_data_o  = state_q.rdata;

    // R1: reset leaves a clean bank and no pending result
    a_r1_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (regs_o == '0 && !rd_valid_o));

    // R6 and R7: the doorbell reads 1 after any send
    a_r6_send_sets_doorbell: assert property (@(posedge clk_i) disable iff (rst_i)
        send_i |=> (regs_o[DOORBELL*DATA_W +: DATA_W] == DATA_W'(1)));

    // R9: a result marked as bank data follows a bank read request
    a_r9_bank_result_source: assert property (@(posedge clk_i) disable iff (rst_i)
        bank_re_i |=> (rd_valid_o && rd_bank_o));

endmodule

// File: rtl/mmio_route_unit.sv
module mmio_route_unit
    import mmio_route_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 5,
    parameter logic [ADDR_W-1:0] PERIPH_BASE = 16'h4000
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [1:0]                 req_op_i,
    input  logic [ADDR_W-1:0]          req_base_i,
    input  logic [ADDR_W-1:0]          req_imm_i,
    input  logic [DATA_W-1:0]          req_wdata_i,
    input  logic                       send_i,
    output logic [ADDR_W-1:0]          cache_addr_o,
    output logic [DATA_W-1:0]          cache_wdata_o,
    output logic                       cache_we_o,
    output logic                       cache_re_o,
    input  logic [DATA_W-1:0]          cache_rdata_i,
    output logic                       rd_valid_o,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0]  idx;
    logic              bank_we;
    logic              bank_re;
    logic              rd_bank;
    logic [DATA_W-1:0] bank_rdata;

    mmio_addr_decode #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .PERIPH_BASE(PERIPH_BASE)
    ) u_decode (
        .op_i      (req_op_e'(req_op_i)),
        .base_i    (req_base_i),
        .imm_i     (req_imm_i),
        .ea_o      (cache_addr_o),
        .idx_o     (idx),
        .cache_we_o(cache_we_o),
        .cache_re_o(cache_re_o),
        .bank_we_o (bank_we),
        .bank_re_o (bank_re)
    );

    mmio_reg_bank #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we_i      (bank_we),
        .widx_i    (idx),
        .wdata_i   (req_wdata_i),
        .send_i    (send_i),
        .rd_req_i  (cache_re_o | bank_re),
        .bank_re_i (bank_re),
        .ridx_i    (idx),
        .regs_o    (regs_o),
        .rd_valid_o(rd_valid_o),
        .rd_bank_o (rd_bank),
        .rd_data_o (bank_rdata)
    );

    assign cache_wdata_o = req_wdata_i;
    assign rd_data_o     = rd_bank ? bank_rdata : cache_rdata_i;

    // R3 and R4: a bank write never also reaches the cache
    a_r4_no_dual_write: assert property (@(posedge clk_i) disable iff (rst_i)
        bank_we |-> !cache_we_o);

    // R5: a cache store leaves the bank untouched
    a_r5_cache_store_keeps_regs: assert property (@(posedge clk_i) disable iff (rst_i)
        (cache_we_o && !send_i) |=> $stable(regs_o));

    // R10: a cache load yields a result next cycle
    a_r10_cache_load_returns: assert property (@(posedge clk_i) disable iff (rst_i)
        cache_re_o |=> rd_valid_o);

    // R9 and R10: one read target at a time
    a_r9_single_read_target: assert property (@(posedge clk_i) disable iff (rst_i)
        !(cache_re_o && bank_re));

endmodule

// File: tb/tb_mmio_route_unit.sv
module tb_mmio_route_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  req_op;
    logic [15:0] req_base;
    logic [15:0] req_imm;
    logic [31:0] req_wdata;
    logic        send;
    logic [15:0] cache_addr;
    logic [31:0] cache_wdata;
    logic        cache_we;
    logic        cache_re;
    logic [31:0] cache_rdata;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [NREG*32-1:0] regs;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_regs [NREG];
    logic [31:0] exp_q [$];
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_route_unit dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .req_op_i     (req_op),
        .req_base_i   (req_base),
        .req_imm_i    (req_imm),
        .req_wdata_i  (req_wdata),
        .send_i       (send),
        .cache_addr_o (cache_addr),
        .cache_wdata_o(cache_wdata),
        .cache_we_o   (cache_we),
        .cache_re_o   (cache_re),
        .cache_rdata_i(cache_rdata),
        .rd_valid_o   (rd_valid),
        .rd_data_o    (rd_data),
        .regs_o       (regs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int k = 0; k < NREG; k++) begin
            chk(tag, regs[k*32 +: 32], exp_regs[k]);
        end
    endtask

    // drive one request cycle, check combinational cache port, update model
    task automatic issue(input logic [1:0] op, input logic [15:0] base, input logic [15:0] imm,
                         input logic [31:0] wd, input logic snd, input logic [31:0] crd,
                         input string tag);
        logic [15:0] ea;
        logic        inwin;
        int          idx;
        logic        exp_we;
        logic        exp_re;
        @(negedge clk);
        req_op = op; req_base = base; req_imm = imm; req_wdata = wd;
        send = snd; cache_rdata = crd;
        ea = base + imm;
        inwin = (ea >= 16'h4000);
        idx = int'(ea[4:2]);
        exp_we = (op == 2'b10) && !inwin;
        exp_re = (op == 2'b01) && !inwin;
        #1;
        if (op != 2'b00) begin
            chk({tag, " R2 addr"}, {16'h0, cache_addr}, {16'h0, ea});
            chk({tag, " R2 wdata"}, cache_wdata, wd);
            chk({tag, " cache_we"}, {31'h0, cache_we}, {31'h0, exp_we});
            chk({tag, " cache_re"}, {31'h0, cache_re}, {31'h0, exp_re});
        end
        if (op == 2'b01) begin
            if (inwin) exp_q.push_back((idx < NREG) ? exp_regs[idx] : 32'h0);
            else       exp_q.push_back(crd);
        end
        if ((op == 2'b11 || (op == 2'b10 && inwin)) && idx < NREG) exp_regs[idx] = wd;
        if (snd) exp_regs[NREG-1] = 32'h1;
        @(posedge clk);
        #1;
        check_regs({tag, " regs"});
    endtask

    task automatic idle();
        issue(2'b00, 16'h0, 16'h0, 32'h0, 1'b0, 32'h0, "idle");
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #3;
        if (!rst && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R9/R10 unexpected rd_valid actual=%h expected=none", rd_data);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    failures++;
                    $display("FAIL R9/R10 load result actual=%h expected=%h", rd_data, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD*200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_op = 2'b00; req_base = '0; req_imm = '0; req_wdata = '0;
        send = 1'b0; cache_rdata = '0;
        for (int k = 0; k < NREG; k++) exp_regs[k] = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        check_regs("R1 reset");
        chk("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R3 register-store through each general register, R11 positions
        issue(2'b11, 16'h4000, 16'h0008, 32'h33293745, 1'b0, 32'h0, "R3 reg2");
        issue(2'b11, 16'h4000, 16'h0000, 32'hA0A00001, 1'b0, 32'h0, "R3 reg0 R11");
        issue(2'b11, 16'h4000, 16'h0004, 32'hB1B10002, 1'b0, 32'h0, "R3 reg1 R11");
        issue(2'b11, 16'h4000, 16'h000C, 32'hC3C30003, 1'b0, 32'h0, "R3 reg3 R11");
        // R3 register-store below the window still goes to the bank
        issue(2'b11, 16'h0004, 16'h0008, 32'h0000C0DE, 1'b0, 32'h0, "R3 low window");
        // R4 ordinary store in the window
        issue(2'b10, 16'h4004, 16'h0000, 32'h44440044, 1'b0, 32'h0, "R4 store reg1");
        // R5 ordinary store to cache, including the top cache word
        issue(2'b10, 16'h1000, 16'h0020, 32'h55550055, 1'b0, 32'h0, "R5 cache store");
        issue(2'b10, 16'h3FFC, 16'h0000, 32'h5555FFFF, 1'b0, 32'h0, "R5 edge store");
        // R8 byte offset ignored
        issue(2'b10, 16'h4000, 16'h0003, 32'h88880008, 1'b0, 32'h0, "R8 store 0x4003");
        // R6 send alone
        issue(2'b00, 16'h0, 16'h0, 32'h0, 1'b1, 32'h0, "R6 send");
        // preload doorbell with non-1 value, then R7 collision
        issue(2'b11, 16'h4010, 16'h0000, 32'h00000055, 1'b0, 32'h0, "R3 reg4");
        issue(2'b11, 16'h4000, 16'h0010, 32'hDEADBEEF, 1'b1, 32'h0, "R7 doorbell collision");
        issue(2'b11, 16'h4010, 16'h0000, 32'h00000077, 1'b0, 32'h0, "R3 reg4 again");
        issue(2'b10, 16'h4008, 16'h0000, 32'h77770002, 1'b1, 32'h0, "R7 send plus reg2");
        // R9 peripheral loads, R8 offset on a load
        issue(2'b01, 16'h4008, 16'h0000, 32'h0, 1'b0, 32'h0, "R9 load reg2");
        issue(2'b01, 16'h4000, 16'h000E, 32'h0, 1'b0, 32'h0, "R8 load 0x400E");
        issue(2'b11, 16'h4010, 16'h0000, 32'h00000099, 1'b0, 32'h0, "R3 reg4 third");
        issue(2'b01, 16'h4010, 16'h0000, 32'h0, 1'b1, 32'h0, "R9 load with send");
        issue(2'b01, 16'h4010, 16'h0000, 32'h0, 1'b0, 32'h0, "R9 load doorbell after");
        // R10 cache loads back to back
        issue(2'b01, 16'h0100, 16'h0000, 32'h0, 1'b0, 32'h00C0FFEE, "R10 cache load");
        issue(2'b01, 16'h3FF0, 16'h000C, 32'h0, 1'b0, 32'h12345678, "R10 cache load edge");
        // load then store then load of reg0
        issue(2'b01, 16'h4000, 16'h0000, 32'h0, 1'b0, 32'h0, "R9 load reg0");
        issue(2'b10, 16'h4000, 16'h0000, 32'hFACE0000, 1'b0, 32'h0, "R4 store reg0");
        issue(2'b01, 16'h4000, 16'h0000, 32'h0, 1'b0, 32'h0, "R9 load reg0 new");
        idle();
        idle();
        chk("R9/R10 scoreboard drained", exp_q.size(), 32'h0);

        // R1 reset after writes
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        for (int k = 0; k < NREG; k++) exp_regs[k] = 32'h0;
        check_regs("R1 reset after writes");
        chk("R1 rd_valid after reset", {31'h0, rd_valid}, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule